// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits on a simple memory-mapped register bus and manages a 128-word by 32-bit array of one-time-programmable fuses. The array is modelled as storage whose bits can only go from 0 to 1. Software reads fuse contents through a window of shadow registers, one per fuse word. Software can refresh these shadows with a single request that copies the whole array into them.

To burn a word, software writes the word address and a 16-bit unlock key into the control register, then writes the value into the data register. The data write starts the program cycle only when the key matches. The key is wiped after every attempt. The sequencer times each operation with cycle counts that software stores in the timing register. Each operation runs a relax phase, a strobe phase and a second relax phase. Busy and error flags in the control register tell software when the block is idle and whether a request was refused. A second address for the control register ORs written ones into it, so software can set single flags without a read-modify-write.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, the control register, the timing register, the data register and every shadow word read as 0, and both strobe outputs are low.
- R2: A write to offset 0x000 loads the word address (bits 6:0) and the key (bits 31:16). A write to offset 0x004 ORs bits 6:0 and 31:16 into those fields, and a 1 in bit 9 there sets the error flag. The control register reads as key[31:16], reload[10], error[9], busy[8], address[6:0], with all other bits 0.
- R3: The timing register at offset 0x010 stores program strobe width in bits 11:0, relax width in bits 15:12 and read strobe width in bits 21:16. It reads back with bits 31:22 at 0.
- R4: A write to the data register (offset 0x020) while idle with key 0x3E77 starts a program operation. Busy stays high for (relax+1)+(prog+1)+(relax+1) cycles, and the program strobe output is high for prog+1 of them. The data register reads back the last value written.
- R5: Programming leaves the addressed fuse word equal to its old value ORed with the data value.
- R6: A data write with a wrong key, a data write while busy, or a reload request (bit 10 written as 1 at offset 0x000 or 0x004) while busy sets the error flag and starts nothing. A write to offset 0x000 with bit 9 at 0 clears the flag, unless the same write is itself refused.
- R7: Every data write clears the key field to 0, whether it starts a program or not.
- R8: An accepted reload request sets bit 10 and busy. It copies all 128 fuse words into their shadows, taking (relax+1)+(read+1)+(relax+1) cycles per word with the read strobe high for read+1 of them. Bit 10 clears by itself when the last word is done.
- R9: Shadow word n (0 to 127) reads at offset 0x400 + 16*n.
- R10: A program operation leaves the shadow words unchanged. New fuse values appear only after a reload.
- R11: The program and read strobes are never high together, and neither is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write enable when selected |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fuse_prog_stb | output | 1 | Program strobe to the fuse array |
| fuse_read_stb | output | 1 | Read strobe to the fuse array |

## Verification
Two things can land in the same cycle: a reload request and the last busy cycle of a program operation. The bench places the request so that the bus samples it on the clock edge where the sequencer leaves its final relax phase. That request must be refused with the error flag set and the reload bit clear. The same request issued one cycle later, with busy low, must be accepted. A data write in the cycle right after a program starts provokes the other collision. The bench judges both cases through the control register and the shadow contents after a later reload.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int unsigned OTP_WORDS   = 128;
  localparam int unsigned OTP_WIDTH   = 32;
  localparam int unsigned OTP_AW      = $clog2(OTP_WORDS);
  localparam int unsigned BUS_AW      = 12;
  localparam int unsigned PROG_W      = 12;
  localparam int unsigned RELAX_W     = 4;
  localparam int unsigned READ_W      = 6;

  localparam logic [BUS_AW-1:0] OFS_CTRL   = 12'h000;
  localparam logic [BUS_AW-1:0] OFS_SET    = 12'h004;
  localparam logic [BUS_AW-1:0] OFS_TIMING = 12'h010;
  localparam logic [BUS_AW-1:0] OFS_DATA   = 12'h020;
  localparam logic [BUS_AW-5:0] SHADOW_ROW = 8'h40;

  localparam int unsigned BIT_BUSY   = 8;
  localparam int unsigned BIT_ERR    = 9;
  localparam int unsigned BIT_RELOAD = 10;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_STB  = 2'd2,
    PH_POST = 2'd3
  } phase_e;
endpackage

// File: rtl/otp_rst_sync.sv
module otp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/otp_word_store.sv
module otp_word_store #(
  parameter int unsigned WORDS    = 128,
  parameter int unsigned WIDTH    = 32,
  parameter bit          OR_WRITE = 1'b0,
  localparam int unsigned AW      = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [WORDS];
  logic [WIDTH-1:0] wval;

  generate
    if (OR_WRITE) begin : g_fuse
      assign wval = mem_q[waddr] | wdata;
    end else begin : g_plain
      assign wval = wdata;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wval;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int unsigned WORDS = 128,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(WORDS),
  localparam int unsigned CW   = PROG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_prog,
  input  logic               start_reload,
  input  logic [AW-1:0]      prog_addr,
  input  logic [WIDTH-1:0]   prog_data,
  input  logic [RELAX_W-1:0] relax_w,
  input  logic [PROG_W-1:0]  prog_w,
  input  logic [READ_W-1:0]  read_w,
  output logic               busy,
  output logic               prog_stb,
  output logic               read_stb,
  output logic               fuse_we,
  output logic               shadow_we,
  output logic [AW-1:0]      word,
  output logic [WIDTH-1:0]   wdata,
  output logic               reload_done
);
  localparam logic [AW-1:0] LAST_WORD = AW'(WORDS - 1);

  phase_e             ph_q, ph_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [AW-1:0]      word_q, word_d;
  logic               is_reload_q, is_reload_d;
  logic [RELAX_W-1:0] relax_q;
  logic [PROG_W-1:0]  progw_q;
  logic [READ_W-1:0]  readw_q;
  logic [WIDTH-1:0]   data_q;
  logic               start;
  logic               last_cnt;
  logic               op_end;

  assign start    = start_prog | start_reload;
  assign last_cnt = (cnt_q == '0);
  assign op_end   = (ph_q == PH_POST) && last_cnt &&
                    (!is_reload_q || word_q == LAST_WORD);

  always_comb begin
    ph_d        = ph_q;
    cnt_d       = cnt_q;
    word_d      = word_q;
    is_reload_d = is_reload_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d        = PH_PRE;
          cnt_d       = CW'(relax_w);
          word_d      = start_prog ? prog_addr : '0;
          is_reload_d = start_reload;
        end
      end
      PH_PRE: begin
        if (last_cnt) begin
          ph_d  = PH_STB;
          cnt_d = is_reload_q ? CW'(readw_q) : progw_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STB: begin
        if (last_cnt) begin
          ph_d  = PH_POST;
          cnt_d = CW'(relax_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_POST: begin
        if (op_end) begin
          ph_d = PH_IDLE;
        end else if (last_cnt) begin
          ph_d   = PH_PRE;
          cnt_d  = CW'(relax_q);
          word_d = word_q + 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      cnt_q       <= '0;
      word_q      <= '0;
      is_reload_q <= 1'b0;
    end else begin
      ph_q        <= ph_d;
      cnt_q       <= cnt_d;
      word_q      <= word_d;
      is_reload_q <= is_reload_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      relax_q <= '0;
      progw_q <= '0;
      readw_q <= '0;
      data_q  <= '0;
    end else if (start && ph_q == PH_IDLE) begin
      relax_q <= relax_w;
      progw_q <= prog_w;
      readw_q <= read_w;
      data_q  <= prog_data;
    end
  end

  assign busy        = (ph_q != PH_IDLE);
  assign prog_stb    = (ph_q == PH_STB) && !is_reload_q;
  assign read_stb    = (ph_q == PH_STB) && is_reload_q;
  assign fuse_we     = prog_stb && last_cnt;
  assign shadow_we   = read_stb && last_cnt;
  assign word        = word_q;
  assign wdata       = data_q;
  assign reload_done = op_end && is_reload_q;
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              fuse_prog_stb,
  output logic              fuse_read_stb
);
  localparam int unsigned AW = OTP_AW;

  logic rst_ns;

  logic [AW-1:0]      ctl_addr_q, ctl_addr_d;
  logic [15:0]        ctl_key_q, ctl_key_d;
  logic               ctl_err_q, ctl_err_d;
  logic               ctl_reload_q, ctl_reload_d;
  logic [RELAX_W-1:0] tim_relax_q;
  logic [PROG_W-1:0]  tim_prog_q;
  logic [READ_W-1:0]  tim_read_q;
  logic [31:0]        data_q;

  logic wr_ctl, wr_set, wr_tim, wr_dat;
  logic req_reload, start_prog, start_reload, refuse;
  logic key_ok;

  logic              busy, fuse_we, shadow_we, reload_done;
  logic [AW-1:0]     seq_word;
  logic [OTP_WIDTH-1:0] seq_wdata, fuse_rdata, shadow_rdata;
  logic [BUS_AW-5:0] row_ofs;
  logic              sh_hit;
  logic [AW-1:0]     sh_idx;

  otp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  assign wr_ctl = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
  assign wr_set = bus_sel && bus_wr && (bus_addr == OFS_SET);
  assign wr_tim = bus_sel && bus_wr && (bus_addr == OFS_TIMING);
  assign wr_dat = bus_sel && bus_wr && (bus_addr == OFS_DATA);

  assign key_ok       = (ctl_key_q == UNLOCK_KEY);
  assign req_reload   = (wr_ctl || wr_set) && bus_wdata[BIT_RELOAD];
  assign start_reload = req_reload && !busy;
  assign start_prog   = wr_dat && !busy && key_ok;
  assign refuse       = (req_reload && busy) || (wr_dat && (busy || !key_ok));

  always_comb begin
    ctl_addr_d   = ctl_addr_q;
    ctl_key_d    = ctl_key_q;
    ctl_err_d    = ctl_err_q;
    ctl_reload_d = ctl_reload_q;
    if (wr_ctl) begin
      ctl_addr_d = bus_wdata[AW-1:0];
      ctl_key_d  = bus_wdata[31:16];
      if (!bus_wdata[BIT_ERR]) ctl_err_d = 1'b0;
    end else if (wr_set) begin
      ctl_addr_d = ctl_addr_q | bus_wdata[AW-1:0];
      ctl_key_d  = ctl_key_q | bus_wdata[31:16];
      if (bus_wdata[BIT_ERR]) ctl_err_d = 1'b1;
    end else if (wr_dat) begin
      ctl_key_d = '0;
    end
    if (refuse) ctl_err_d = 1'b1;
    if (start_reload)      ctl_reload_d = 1'b1;
    else if (reload_done)  ctl_reload_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ctl_addr_q   <= '0;
      ctl_key_q    <= '0;
      ctl_err_q    <= 1'b0;
      ctl_reload_q <= 1'b0;
    end else begin
      ctl_addr_q   <= ctl_addr_d;
      ctl_key_q    <= ctl_key_d;
      ctl_err_q    <= ctl_err_d;
      ctl_reload_q <= ctl_reload_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      tim_relax_q <= '0;
      tim_prog_q  <= '0;
      tim_read_q  <= '0;
    end else if (wr_tim) begin
      tim_prog_q  <= bus_wdata[PROG_W-1:0];
      tim_relax_q <= bus_wdata[PROG_W+RELAX_W-1:PROG_W];
      tim_read_q  <= bus_wdata[16+READ_W-1:16];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     data_q <= '0;
    else if (wr_dat) data_q <= bus_wdata;
  end

  otp_seq #(.WORDS(OTP_WORDS), .WIDTH(OTP_WIDTH)) u_seq (
    .clk          (clk),
    .rst_n        (rst_ns),
    .start_prog   (start_prog),
    .start_reload (start_reload),
    .prog_addr    (ctl_addr_q),
    .prog_data    (bus_wdata),
    .relax_w      (tim_relax_q),
    .prog_w       (tim_prog_q),
    .read_w       (tim_read_q),
    .busy         (busy),
    .prog_stb     (fuse_prog_stb),
    .read_stb     (fuse_read_stb),
    .fuse_we      (fuse_we),
    .shadow_we    (shadow_we),
    .word         (seq_word),
    .wdata        (seq_wdata),
    .reload_done  (reload_done)
  );

  otp_word_store #(.WORDS(OTP_WORDS), .WIDTH(OTP_WIDTH), .OR_WRITE(1'b1)) u_fuse (
    .clk   (clk),
    .rst_n (rst_ns),
    .we    (fuse_we),
    .waddr (seq_word),
    .wdata (seq_wdata),
    .raddr (seq_word),
    .rdata (fuse_rdata)
  );

  assign row_ofs = bus_addr[BUS_AW-1:4] - SHADOW_ROW;
  assign sh_hit  = (bus_addr[3:0] == 4'h0) && (bus_addr[BUS_AW-1:4] >= SHADOW_ROW) &&
                   (row_ofs < (BUS_AW-4)'(OTP_WORDS));
  assign sh_idx  = row_ofs[AW-1:0];

  otp_word_store #(.WORDS(OTP_WORDS), .WIDTH(OTP_WIDTH), .OR_WRITE(1'b0)) u_shadow (
    .clk   (clk),
    .rst_n (rst_ns),
    .we    (shadow_we),
    .waddr (seq_word),
    .wdata (fuse_rdata),
    .raddr (sh_idx),
    .rdata (shadow_rdata)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CTRL || bus_addr == OFS_SET) begin
      bus_rdata[31:16]      = ctl_key_q;
      bus_rdata[BIT_RELOAD] = ctl_reload_q;
      bus_rdata[BIT_ERR]    = ctl_err_q;
      bus_rdata[BIT_BUSY]   = busy;
      bus_rdata[AW-1:0]     = ctl_addr_q;
    end else if (bus_addr == OFS_TIMING) begin
      bus_rdata[PROG_W-1:0]             = tim_prog_q;
      bus_rdata[PROG_W+RELAX_W-1:PROG_W] = tim_relax_q;
      bus_rdata[16+READ_W-1:16]         = tim_read_q;
    end else if (bus_addr == OFS_DATA) begin
      bus_rdata = data_q;
    end else if (sh_hit) begin
      bus_rdata = shadow_rdata;
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk
  import otp_pkg::*;
(
  input logic              clk,
  input logic              rst_ns,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [15:0]       key,
  input logic              err,
  input logic              reload,
  input logic              busy,
  input logic              prog_stb,
  input logic              read_stb
);
  logic dat_wr;
  assign dat_wr = bus_sel && bus_wr && (bus_addr == OFS_DATA);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    !(prog_stb && read_stb));

  p_strobe_busy_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    (prog_stb || read_stb) |-> busy);

  p_reload_busy_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    reload |-> busy);

  p_key_wipe_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    dat_wr |=> (key == 16'h0000));

  p_busy_refuse_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (dat_wr && busy) |=> err);

  p_prog_start_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (dat_wr && !busy && key == UNLOCK_KEY) |=> (busy && !reload));
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .key      (ctl_key_q),
  .err      (ctl_err_q),
  .reload   (ctl_reload_q),
  .busy     (busy),
  .prog_stb (fuse_prog_stb),
  .read_stb (fuse_read_stb)
);

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        fuse_prog_stb;
  logic        fuse_read_stb;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  event mon_ev;

  otp_fuse_ctrl u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .fuse_prog_stb (fuse_prog_stb),
    .fuse_read_stb (fuse_read_stb)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // monitor: pops expected reads and compares against the bus
  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: addr 0x%03h actual 0x%08h expected 0x%08h",
                   it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic cmp(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    bus_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    #1;
    ->mon_ev;
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // counts cycles with busy high, starting at the current negedge
  task automatic count_busy(output int nbusy, output int nprog, output int nread);
    nbusy = 0; nprog = 0; nread = 0;
    bus_addr = 12'h000;
    #1;
    while (bus_rdata[8] && nbusy < 5000) begin
      nbusy++;
      if (fuse_prog_stb) nprog++;
      if (fuse_read_stb) nread++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wait_idle();
    int n, p, r;
    count_busy(n, p, r);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int nb, np, nr;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(12'h000, 32'h0, "R1 ctrl");
    rd(12'h010, 32'h0, "R1 timing");
    rd(12'h020, 32'h0, "R1 data");
    rd(12'h400, 32'h0, "R1 shadow0");
    rd(12'hBF0, 32'h0, "R1 shadow127");
    cmp(int'(fuse_prog_stb) + int'(fuse_read_stb), 0, "R1 strobes");

    // R3 timing fields
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, 32'h003F_FFFF, "R3 timing mask");
    wr(12'h010, 32'h0000_1002);  // relax 1, prog 2, read 0
    rd(12'h010, 32'h0000_1002, "R3 timing value");

    // R2 control write, R4 program with key
    wr(12'h000, 32'h3E77_0005);
    rd(12'h000, 32'h3E77_0005, "R2 ctrl load");
    wr(12'h020, 32'h0000_00A5);
    count_busy(nb, np, nr);
    cmp(nb, 7, "R4 program busy cycles");
    cmp(np, 3, "R4 program strobe cycles");
    cmp(nr, 0, "R11 no read strobe in program");
    rd(12'h000, 32'h0000_0005, "R7 key cleared after program");
    rd(12'h020, 32'h0000_00A5, "R4 data readback");
    rd(12'h450, 32'h0, "R10 shadow not updated by program");

    // R8 reload
    wr(12'h004, 32'h0000_0400);
    rd(12'h000, 32'h0000_0505, "R8 reload and busy set");
    count_busy(nb, np, nr);
    cmp(nb + 1, 640, "R8 reload busy cycles");
    cmp(nr, 128, "R8 read strobe cycles");
    cmp(np, 0, "R11 no program strobe in reload");
    rd(12'h000, 32'h0000_0005, "R8 reload bit self-clears");
    rd(12'h450, 32'h0000_00A5, "R8 shadow word 5 after reload");

    // R5 OR semantics
    wr(12'h000, 32'h3E77_0005);
    wr(12'h020, 32'h0000_000F);
    wait_idle();
    wr(12'h004, 32'h0000_0400);
    wait_idle();
    rd(12'h450, 32'h0000_00AF, "R5 fuse OR result");

    // R6 wrong key
    wr(12'h000, 32'h1234_0006);
    wr(12'h020, 32'h0000_00FF);
    rd(12'h000, 32'h0000_0206, "R6 wrong key sets error, R7 key cleared");
    wr(12'h000, 32'h0000_0006);
    rd(12'h000, 32'h0000_0006, "R6 error cleared by ctrl write");

    // R2 set alias
    wr(12'h000, 32'h0000_0010);
    wr(12'h004, 32'h3E77_0001);
    rd(12'h000, 32'h3E77_0011, "R2 set alias OR");
    wr(12'h004, 32'h0000_0200);
    rd(12'h000, 32'h3E77_0211, "R2 set alias error bit");

    // program word 127 (clears error too)
    wr(12'h000, 32'h3E77_007F);
    wr(12'h020, 32'h8000_0001);
    wait_idle();

    // R6 data write while busy
    wr(12'h000, 32'h3E77_0000);
    wr(12'h020, 32'h1234_5678);
    wr(12'h020, 32'hFFFF_FFFF);
    wait_idle();
    rd(12'h000, 32'h0000_0200, "R6 data write while busy refused");
    wr(12'h000, 32'h0000_0000);

    // R6 reload request in the last busy cycle of a program
    wr(12'h000, 32'h3E77_0011);
    wr(12'h020, 32'hFFFF_0000);
    repeat (5) @(negedge clk);
    wr(12'h004, 32'h0000_0400);
    rd(12'h000, 32'h0000_0211, "R6 reload in last busy cycle refused");
    wr(12'h000, 32'h0000_0411);
    rd(12'h000, 32'h0000_0511, "R8 reload accepted once idle");
    wait_idle();

    // R9 shadow window mapping
    rd(12'h510, 32'hFFFF_0000, "R9 shadow word 17");
    rd(12'hBF0, 32'h8000_0001, "R9 shadow word 127");
    rd(12'h400, 32'h1234_5678, "R9 shadow word 0");
    rd(12'h450, 32'h0000_00AF, "R9 shadow word 5");
    rd(12'h460, 32'h0000_0000, "R6 wrong key left word 6 blank");

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule